// File: doc/BRIEF.md
# Add/Subtract Status Flag Generator

This block produces the arithmetic status flags for one add or subtract operation on two operands at a chosen width of 8, 16 or 32 bits. It returns the result truncated to that width and six individual flags: carry (or borrow), parity, auxiliary carry, zero, sign and overflow. It also builds a 32-bit saved flags word. In that word the six arithmetic flags sit at fixed positions, the reserved bits are forced to their fixed values, and the remaining control bits are taken unchanged from the previous flags word.

The block is purely combinational. An execution stage feeds it the operands, the incoming carry, the operation and the width. It reads the flags in the same cycle. It stores the packed word when flags are saved to memory.

Top module: `alu_status_flags`

## Requirements
- R1: `carry_flag` is the carry out of the top bit of the selected width when `op_sub`=0. When `op_sub`=1 it is the borrow into that bit, so `a_in - b_in - carry_in` is negative when read as unsigned values of that width. Add computes `a_in + b_in + carry_in`.
- R2: `ovf_flag` is 1 exactly when the signed result at the selected width does not fit that width. This is the case where the carry into the sign bit differs from the carry out of it.
- R3: `sign_flag` equals the top bit of the selected width of the result: bit 7, 15 or 31.
- R4: `zero_flag` is 1 only when every result bit inside the selected width is 0.
- R5: `aux_flag` is the carry out of bit 3 (add) or the borrow into bit 3 (subtract) of the low four bits including `carry_in`, whatever the width.
- R6: `parity_flag` is 1 when `result[7:0]` holds an even number of ones, whatever the width.
- R7: `width_sel` codes are 00 for 8 bits, 01 for 16 bits, and 10 or 11 for 32 bits. Result bits above the selected width are 0, and operand bits above it have no effect on any output.
- R8: `flags_word` holds carry at bit 0, parity at bit 2, aux at bit 4, zero at bit 6, sign at bit 7 and overflow at bit 11. Bits 8-10, 12-14 and 16-18 are copied from `prior_word`.
- R9: `flags_word` bit 1 is always 1. Bits 3, 5, 15 and 19 through 31 are always 0, whatever `prior_word` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand (subtrahend on subtract) |
| carry_in | input | 1 | Incoming carry, or borrow on subtract |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| width_sel | input | 2 | Operand width code |
| prior_word | input | 32 | Previous flags word supplying the control bits |
| result | output | 32 | Result, zero above the selected width |
| carry_flag | output | 1 | Carry / borrow flag |
| parity_flag | output | 1 | Even parity of the low result byte |
| aux_flag | output | 1 | Bit-3 carry / borrow flag |
| zero_flag | output | 1 | Zero result flag |
| sign_flag | output | 1 | Result sign flag |
| ovf_flag | output | 1 | Signed overflow flag |
| flags_word | output | 32 | Packed saved flags word |

## Verification
The bench builds the block with the default `DATA_W` of 32, which places the three width boundaries at bits 7, 15 and 31. At that setting every width code and every sign and carry position can be reached. The bench's vectors push operands across each boundary in both directions, with and without an incoming carry. This exercises signed wrap, unsigned wrap and the bit-3 carry independently of one another. Garbage in the operand bits above the selected width, and an all-ones previous flags word, reach the masking and the forced reserved bits.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int WORD_W = 32;

  // positions of the arithmetic flags in the saved word
  localparam int POS_CF = 0;
  localparam int POS_PF = 2;
  localparam int POS_AF = 4;
  localparam int POS_ZF = 6;
  localparam int POS_SF = 7;
  localparam int POS_OF = 11;
  localparam int POS_ONE = 1;

  // bits forced low in the saved word: 3, 5, 15, 19..31
  localparam logic [WORD_W-1:0] FORCED_LOW = 32'hFFF8_8028;

  typedef enum logic [1:0] {
    WID_BYTE = 2'b00,
    WID_HALF = 2'b01,
    WID_WORD = 2'b10,
    WID_WALT = 2'b11
  } width_e;

  function automatic logic even_ones_byte(input logic [7:0] v);
    return ~(^v);
  endfunction

  function automatic logic full_add_carry(input logic x, input logic y, input logic c);
    return (x & y) | (c & (x ^ y));
  endfunction
endpackage

// File: rtl/alu_ripple_core.sv
module alu_ripple_core #(
  parameter int DATA_W = alu_flag_pkg::WORD_W
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              cin,
  input  logic              sub,
  output logic [DATA_W-1:0] raw_sum,
  output logic [DATA_W:0]   carry_chain
);
  logic [DATA_W-1:0] b_eff;

  // subtract as a + ~b + ~borrow_in
  assign b_eff          = sub ? ~op_b : op_b;
  assign carry_chain[0] = sub ? ~cin : cin;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign raw_sum[i]       = op_a[i] ^ b_eff[i] ^ carry_chain[i];
    assign carry_chain[i+1] = alu_flag_pkg::full_add_carry(op_a[i], b_eff[i], carry_chain[i]);
  end
endmodule

// File: rtl/alu_width_slice.sv
module alu_width_slice #(
  parameter int DATA_W = alu_flag_pkg::WORD_W
) (
  input  logic [1:0]        width_sel,
  input  logic [DATA_W-1:0] raw_sum,
  input  logic [DATA_W:0]   carry_chain,
  output logic [DATA_W-1:0] width_mask,
  output logic [DATA_W-1:0] masked_sum,
  output logic              carry_top,
  output logic              carry_sign_in,
  output logic              sign_bit
);
  import alu_flag_pkg::*;

  localparam int W_BYTE = DATA_W / 4;
  localparam int W_HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] MASK_BYTE = {{(DATA_W-W_BYTE){1'b0}}, {W_BYTE{1'b1}}};
  localparam logic [DATA_W-1:0] MASK_HALF = {{(DATA_W-W_HALF){1'b0}}, {W_HALF{1'b1}}};

  always_comb begin
    case (width_e'(width_sel))
      WID_BYTE: begin
        width_mask    = MASK_BYTE;
        carry_top     = carry_chain[W_BYTE];
        carry_sign_in = carry_chain[W_BYTE-1];
        sign_bit      = raw_sum[W_BYTE-1];
      end
      WID_HALF: begin
        width_mask    = MASK_HALF;
        carry_top     = carry_chain[W_HALF];
        carry_sign_in = carry_chain[W_HALF-1];
        sign_bit      = raw_sum[W_HALF-1];
      end
      default: begin
        width_mask    = '1;
        carry_top     = carry_chain[DATA_W];
        carry_sign_in = carry_chain[DATA_W-1];
        sign_bit      = raw_sum[DATA_W-1];
      end
    endcase
  end

  assign masked_sum = raw_sum & width_mask;
endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval #(
  parameter int DATA_W = alu_flag_pkg::WORD_W
) (
  input  logic [DATA_W-1:0] masked_sum,
  input  logic              sub,
  input  logic              carry_top,
  input  logic              carry_sign_in,
  input  logic              carry_nibble,
  input  logic              sign_bit,
  output logic              cf,
  output logic              pf,
  output logic              af,
  output logic              zf,
  output logic              sf,
  output logic              of
);
  // raw adder carries become borrows on subtract
  assign cf = carry_top ^ sub;
  assign af = carry_nibble ^ sub;
  assign of = carry_top ^ carry_sign_in;
  assign sf = sign_bit;
  assign zf = (masked_sum == '0);
  assign pf = alu_flag_pkg::even_ones_byte(masked_sum[7:0]);

  always_comb begin
    AST_AUX_SUB_INVERT: assert (!sub || (af == ~carry_nibble))  // R5
      else $error("aux flag not inverted on subtract");
  end
endmodule

// File: rtl/alu_flag_pack.sv
module alu_flag_pack #(
  parameter int WORD_W = alu_flag_pkg::WORD_W
) (
  input  logic              cf,
  input  logic              pf,
  input  logic              af,
  input  logic              zf,
  input  logic              sf,
  input  logic              of,
  input  logic [WORD_W-1:0] prior_word,
  output logic [WORD_W-1:0] flags_word
);
  import alu_flag_pkg::*;

  for (genvar i = 0; i < WORD_W; i++) begin : g_pos
    if (i == POS_CF) begin : g_cf
      assign flags_word[i] = cf;
    end else if (i == POS_PF) begin : g_pf
      assign flags_word[i] = pf;
    end else if (i == POS_AF) begin : g_af
      assign flags_word[i] = af;
    end else if (i == POS_ZF) begin : g_zf
      assign flags_word[i] = zf;
    end else if (i == POS_SF) begin : g_sf
      assign flags_word[i] = sf;
    end else if (i == POS_OF) begin : g_of
      assign flags_word[i] = of;
    end else if (i == POS_ONE) begin : g_one
      assign flags_word[i] = 1'b1;
    end else if (FORCED_LOW[i]) begin : g_zero
      assign flags_word[i] = 1'b0;
    end else begin : g_keep
      assign flags_word[i] = prior_word[i];
    end
  end

  always_comb begin
    AST_IMAGE_ARITH_POS: assert (flags_word[POS_ZF] == zf && flags_word[POS_SF] == sf)  // R8
      else $error("zero/sign not at their image positions");
  end
endmodule

// File: rtl/alu_status_flags.sv
module alu_status_flags #(
  parameter int DATA_W = alu_flag_pkg::WORD_W
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              carry_in,
  input  logic              op_sub,
  input  logic [1:0]        width_sel,
  input  logic [DATA_W-1:0] prior_word,
  output logic [DATA_W-1:0] result,
  output logic              carry_flag,
  output logic              parity_flag,
  output logic              aux_flag,
  output logic              zero_flag,
  output logic              sign_flag,
  output logic              ovf_flag,
  output logic [DATA_W-1:0] flags_word
);
  logic [DATA_W-1:0] raw_sum;
  logic [DATA_W:0]   carry_chain;
  logic [DATA_W-1:0] width_mask;
  logic              carry_top;
  logic              carry_sign_in;
  logic              sign_bit;

  alu_ripple_core #(.DATA_W(DATA_W)) core_i (
    .op_a        (a_in),
    .op_b        (b_in),
    .cin         (carry_in),
    .sub         (op_sub),
    .raw_sum     (raw_sum),
    .carry_chain (carry_chain)
  );

  alu_width_slice #(.DATA_W(DATA_W)) slice_i (
    .width_sel     (width_sel),
    .raw_sum       (raw_sum),
    .carry_chain   (carry_chain),
    .width_mask    (width_mask),
    .masked_sum    (result),
    .carry_top     (carry_top),
    .carry_sign_in (carry_sign_in),
    .sign_bit      (sign_bit)
  );

  alu_flag_eval #(.DATA_W(DATA_W)) eval_i (
    .masked_sum    (result),
    .sub           (op_sub),
    .carry_top     (carry_top),
    .carry_sign_in (carry_sign_in),
    .carry_nibble  (carry_chain[4]),
    .sign_bit      (sign_bit),
    .cf            (carry_flag),
    .pf            (parity_flag),
    .af            (aux_flag),
    .zf            (zero_flag),
    .sf            (sign_flag),
    .of            (ovf_flag)
  );

  alu_flag_pack #(.WORD_W(DATA_W)) pack_i (
    .cf         (carry_flag),
    .pf         (parity_flag),
    .af         (aux_flag),
    .zf         (zero_flag),
    .sf         (sign_flag),
    .of         (ovf_flag),
    .prior_word (prior_word),
    .flags_word (flags_word)
  );

  // cross-module checks at the port level
  logic [DATA_W-1:0] msb_pick;
  logic              a_neg, b_neg, r_neg;
  assign msb_pick = width_mask ^ (width_mask >> 1);
  assign a_neg    = |(a_in & msb_pick);
  assign b_neg    = |(b_in & msb_pick);
  assign r_neg    = |(result & msb_pick);

  always_comb begin
    AST_ADD_CARRY_WRAP: assert (op_sub || carry_in || (carry_flag == (result < (a_in & width_mask))))  // R1
      else $error("add carry disagrees with unsigned wrap");
    AST_SUB_BORROW_CMP: assert (!op_sub || carry_in || (carry_flag == ((a_in & width_mask) < (b_in & width_mask))))  // R1
      else $error("subtract borrow disagrees with compare");
    AST_NO_OVERFLOW: assert (!ovf_flag || ((op_sub ? (a_neg != b_neg) : (a_neg == b_neg)) && (r_neg != a_neg)))  // R2
      else $error("overflow with impossible operand signs");
    AST_SIGN_MSB: assert (sign_flag == r_neg)  // R3
      else $error("sign flag not the width msb");
    AST_ZERO_RESULT: assert (zero_flag == (result == '0))  // R4
      else $error("zero flag disagrees with result");
    AST_UPPER_CLEAR: assert ((result & ~width_mask) == '0)  // R7
      else $error("result bits above width not zero");
    AST_IMAGE_CARRY_OVF: assert (flags_word[0] == carry_flag && flags_word[11] == ovf_flag)  // R8
      else $error("carry/overflow misplaced in image");
  end
endmodule

// File: tb/alu_status_flags_tb_top.sv
module alu_status_flags_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [31:0] a_in, b_in, prior_word;
  logic        carry_in, op_sub;
  logic [1:0]  width_sel;
  logic [31:0] result, flags_word;
  logic        carry_flag, parity_flag, aux_flag, zero_flag, sign_flag, ovf_flag;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  alu_status_flags dut_i (
    .a_in(a_in), .b_in(b_in), .carry_in(carry_in), .op_sub(op_sub),
    .width_sel(width_sel), .prior_word(prior_word), .result(result),
    .carry_flag(carry_flag), .parity_flag(parity_flag), .aux_flag(aux_flag),
    .zero_flag(zero_flag), .sign_flag(sign_flag), .ovf_flag(ovf_flag),
    .flags_word(flags_word)
  );

  // {width(2), sub(1), cin(1), a(32), b(32)}
  localparam int NV = 18;
  localparam logic [67:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b0, 32'h0000_007F, 32'h0000_0001},
    {2'b00, 1'b0, 1'b0, 32'h0000_00FF, 32'h0000_0001},
    {2'b00, 1'b0, 1'b1, 32'h0000_0080, 32'h0000_007F},
    {2'b00, 1'b1, 1'b0, 32'h0000_0080, 32'h0000_0001},
    {2'b00, 1'b1, 1'b0, 32'h0000_0010, 32'h0000_0001},
    {2'b00, 1'b1, 1'b1, 32'h0000_0005, 32'h0000_0005},
    {2'b01, 1'b0, 1'b0, 32'h0000_7FFF, 32'h0000_0001},
    {2'b01, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_0001},
    {2'b01, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0001},
    {2'b01, 1'b1, 1'b0, 32'h0000_8000, 32'h0000_0001},
    {2'b01, 1'b0, 1'b1, 32'h0000_1238, 32'h0000_0007},
    {2'b10, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001},
    {2'b10, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001},
    {2'b10, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_0001},
    {2'b10, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_0000},
    {2'b10, 1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000},
    {2'b11, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001},
    {2'b00, 1'b0, 1'b0, 32'hABCD_EF0F, 32'h1234_5601}
  };

  localparam logic [31:0] KEEP_BITS = 32'h0007_7700;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] w, input logic s, input logic c,
                       input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic ecf, output logic eof,
                       output logic esf, output logic ezf, output logic eaf, output logic epf);
    int wd;
    longint m, half, am, bm, sa, sb, full, sr;
    int na;
    wd   = (w == 2'b00) ? 8 : (w == 2'b01) ? 16 : 32;
    m    = (longint'(1) << wd) - 1;
    half = (m + 1) / 2;
    am   = longint'(a) & m;
    bm   = longint'(b) & m;
    sa   = (am >= half) ? am - (m + 1) : am;
    sb   = (bm >= half) ? bm - (m + 1) : bm;
    if (!s) begin
      full = am + bm + longint'(c);
      ecf  = (full > m);
      sr   = sa + sb + longint'(c);
      na   = int'(a[3:0]) + int'(b[3:0]) + int'(c);
      eaf  = (na > 15);
    end else begin
      full = am - bm - longint'(c);
      ecf  = (full < 0);
      sr   = sa - sb - longint'(c);
      na   = int'(a[3:0]) - int'(b[3:0]) - int'(c);
      eaf  = (na < 0);
    end
    r   = 32'(full & m);
    eof = (sr >= half) || (sr < -half);
    esf = r[wd-1];
    ezf = (r == 32'h0);
    epf = ((r[0]+r[1]+r[2]+r[3]+r[4]+r[5]+r[6]+r[7]) % 2) == 0;
  endtask

  function automatic logic [31:0] image(input logic [31:0] pw, input logic ecf, input logic epf,
                                        input logic eaf, input logic ezf, input logic esf,
                                        input logic eof);
    logic [31:0] v;
    v = (pw & KEEP_BITS) | 32'h2;
    v[0] = ecf; v[2] = epf; v[4] = eaf; v[6] = ezf; v[7] = esf; v[11] = eof;
    return v;
  endfunction

  task automatic apply_and_check(input logic [1:0] w, input logic s, input logic c,
                                 input logic [31:0] a, input logic [31:0] b,
                                 input logic [31:0] pw);
    logic [31:0] er;
    logic ecf, eof, esf, ezf, eaf, epf;
    @(posedge clk);
    width_sel = w; op_sub = s; carry_in = c; a_in = a; b_in = b; prior_word = pw;
    @(negedge clk);
    model(w, s, c, a, b, er, ecf, eof, esf, ezf, eaf, epf);
    check(result == er,           "R7", "result",    result, er);
    check(carry_flag == ecf,      "R1", "carry",     32'(carry_flag), 32'(ecf));
    check(ovf_flag == eof,        "R2", "overflow",  32'(ovf_flag), 32'(eof));
    check(sign_flag == esf,       "R3", "sign",      32'(sign_flag), 32'(esf));
    check(zero_flag == ezf,       "R4", "zero",      32'(zero_flag), 32'(ezf));
    check(aux_flag == eaf,        "R5", "aux",       32'(aux_flag), 32'(eaf));
    check(parity_flag == epf,     "R6", "parity",    32'(parity_flag), 32'(epf));
    check(flags_word == image(pw, ecf, epf, eaf, ezf, esf, eof), "R8", "image",
          flags_word, image(pw, ecf, epf, eaf, ezf, esf, eof));
  endtask

  initial begin
    a_in = '0; b_in = '0; carry_in = 1'b0; op_sub = 1'b0; width_sel = 2'b10; prior_word = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // idle state with all-zero inputs: zero and parity set, bit 1 set
    check(flags_word == 32'h0000_0046, "R9", "idle image", flags_word, 32'h0000_0046);
    check(zero_flag == 1'b1, "R4", "idle zero", 32'(zero_flag), 32'h1);

    for (int i = 0; i < NV; i++) begin
      apply_and_check(VEC[i][67:66], VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0],
                      32'h0000_0000);
    end

    // R9: all-ones prior word cannot set the forced-low bits
    apply_and_check(2'b10, 1'b0, 1'b0, 32'h0, 32'h0, 32'hFFFF_FFFF);
    check(flags_word == 32'h0007_7746, "R9", "forced bits", flags_word, 32'h0007_7746);

    // R8: control bits pass from prior word, arithmetic bits do not
    apply_and_check(2'b00, 1'b0, 1'b0, 32'h1, 32'h1, 32'h0005_2500);
    check(flags_word[18:8] == 11'h525, "R8", "kept bits", 32'(flags_word[18:8]), 32'h525);

    // R7: width 8 with junk in upper bits; only low byte matters
    apply_and_check(2'b00, 1'b1, 1'b0, 32'hFFFF_FF00, 32'h0000_0000, 32'h0);
    check(result == 32'h0 && zero_flag, "R7", "upper ignored", result, 32'h0);

    // R6: parity from low byte only at 16 bits
    apply_and_check(2'b01, 1'b0, 1'b0, 32'h0000_0301, 32'h0000_0000, 32'h0);
    check(parity_flag == 1'b0, "R6", "low byte parity", 32'(parity_flag), 32'h0);

    // R5: bit-3 carry at 32 bits
    apply_and_check(2'b10, 1'b0, 1'b1, 32'h0000_000F, 32'h0000_0000, 32'h0);
    check(aux_flag == 1'b1, "R5", "nibble carry", 32'(aux_flag), 32'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule